// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Idle-State Insertion

This block runs external bus accesses for a small bus controller. A requester hands it one access at a time: a target area, a read or write flag, an address, or a flag marking an internal-only access that never reaches the pins. The block drives the address, one active-low select per area, active-low read and write strobes, and an enable that turns the controller's data-bus drivers on. Each area is fixed by parameters as a two-state or three-state area. A three-state area can add zero to three wait states between its second and third states.

Some devices, such as slow ROMs, keep driving the data bus for a while after their read ends. The block keeps a record of the most recent external cycle: whether it was a read, and which area it used. When the next access would collide with a device that is still driving the bus, the block places one idle state in front of that access. Two enable bits, both set at reset, switch the two insertion cases on or off. A mode input marks the large-address operating mode, and the area-crossing read case applies only in that mode.

Top module: `ext_bus_idle_seq`

## Requirements
- R1: An inserted idle state lasts exactly one clock. During it every select is high, both strobes are high and `bus_data_oe` is low. The next state is the first state of the pending cycle.
- R2: An idle state is inserted when a read follows a read to a different area back to back, `rr_en` is 1 and `adv_mode` is 1.
- R3: An idle state is inserted when a write follows a read back to back and `wr_en` is 1, whatever the areas are.
- R4: No idle state is inserted in any other case: reads to the same area, a read after a write, a write after a write, or a case whose enable bit is 0.
- R5: Both enable bits read as 1 after reset. A clock with `cfg_we`=1 loads `rr_en` from `cfg_rr_en` and `wr_en` from `cfg_wr_en`.
- R6: With `adv_mode`=0 no area-crossing read idle state is inserted. Write-after-read insertion is not affected by `adv_mode`.
- R7: The select of the addressed area (bit n of `bus_cs_n` for area n) is low for the whole cycle and no other select is low. A cycle lasts 2 clocks in a two-state area and 3 plus the area's wait count in a three-state area. In the test configuration, areas 0, 1, 2 and 3 last 3, 2, 5 and 4 clocks.
- R8: A read holds `bus_rd_n` low for the whole cycle. A write holds `bus_data_oe` high for the whole cycle and holds `bus_wr_n` low from the cycle's second clock to its end.
- R9: An internal-only access, or a clock in which the bus sits idle, clears the cycle record. The external access that follows gets no idle state.
- R10: `req_ready` is high when the sequencer is idle and in the final clock of a cycle, and low in every other clock, including the inserted idle state. Once out of reset the sequencer is idle with all outputs deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| adv_mode | input | 1 | Large-address operating mode |
| cfg_we | input | 1 | Load the two enable bits |
| cfg_rr_en | input | 1 | New value for area-crossing read insertion |
| cfg_wr_en | input | 1 | New value for write-after-read insertion |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this clock if valid |
| req_internal | input | 1 | Access is internal only, no bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | ABW | Target area |
| req_addr | input | AW | Access address |
| bus_addr | output | AW | External address |
| bus_cs_n | output | AREAS | Active-low area selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_data_oe | output | 1 | Controller drives the data bus |

## Verification
A wrong cycle record or a wrong enable bit shows up in the first clock after the second request is accepted. That clock is either a quiet idle state or the start of a select, and a fault in the record makes it the wrong one. A wrong wait count or state sequence shows up as a select that is held low for too many or too few clocks, or as `req_ready` rising at the wrong clock. The bench checks every ordered pair of areas and access types under all eight settings of the two enable bits and the mode input. It compares the length of each gap and each select window against arithmetic expectations.

// File: rtl/ext_bus_idle_seq.sv
module ext_bus_idle_seq #(
  parameter int AREAS = 4,
  parameter int AW = 16,
  parameter logic [AREAS-1:0] AREA_THREE = 4'b1101,
  parameter logic [2*AREAS-1:0] AREA_WAIT = 8'b01_10_00_00,
  localparam int ABW = (AREAS > 1) ? $clog2(AREAS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_mode,
  input  logic             cfg_we,
  input  logic             cfg_rr_en,
  input  logic             cfg_wr_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_internal,
  input  logic             req_write,
  input  logic [ABW-1:0]   req_area,
  input  logic [AW-1:0]    req_addr,
  output logic [AW-1:0]    bus_addr,
  output logic [AREAS-1:0] bus_cs_n,
  output logic             bus_rd_n,
  output logic             bus_wr_n,
  output logic             bus_data_oe
);

  typedef enum logic [2:0] {S_IDLE, S_TI, S_T1, S_T2, S_TW, S_T3} st_t;

  st_t            state;
  logic [ABW-1:0] cur_area, hist_area;
  logic           cur_write, hist_v, hist_rd;
  logic [AW-1:0]  cur_addr;
  logic [1:0]     wcnt;
  logic           rr_en, wr_en;

  wire       three   = AREA_THREE[cur_area];
  wire [1:0] waits   = AREA_WAIT[{cur_area, 1'b0} +: 2];
  wire       last_st = (state == S_T2 && !three) || state == S_T3;
  wire       active  = state inside {S_T1, S_T2, S_TW, S_T3};
  wire       acc     = req_valid && req_ready;
  wire       need_idle = last_st && hist_v && hist_rd &&
                         (req_write ? wr_en : (req_area != hist_area && rr_en && adv_mode));

  assign req_ready   = state == S_IDLE || last_st;
  assign bus_addr    = cur_addr;
  assign bus_rd_n    = !(active && !cur_write);
  assign bus_wr_n    = !(cur_write && state inside {S_T2, S_TW, S_T3});
  assign bus_data_oe = active && cur_write;

  for (genvar i = 0; i < AREAS; i++) begin : g_cs
    assign bus_cs_n[i] = !(active && cur_area == ABW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_en <= 1'b1;
      wr_en <= 1'b1;
    end else if (cfg_we) begin
      rr_en <= cfg_rr_en;
      wr_en <= cfg_wr_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_area  <= '0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      wcnt      <= '0;
      hist_v    <= 1'b0;
      hist_rd   <= 1'b0;
      hist_area <= '0;
    end else if (acc) begin
      if (req_internal) begin
        state  <= S_IDLE;
        hist_v <= 1'b0;
      end else begin
        cur_area  <= req_area;
        cur_write <= req_write;
        cur_addr  <= req_addr;
        hist_v    <= 1'b1;
        hist_rd   <= !req_write;
        hist_area <= req_area;
        state     <= need_idle ? S_TI : S_T1;
      end
    end else begin
      case (state)
        S_IDLE: hist_v <= 1'b0;
        S_TI:   state <= S_T1;
        S_T1:   state <= S_T2;
        S_T2:
          if (!three) state <= S_IDLE;
          else if (waits != 2'd0) begin
            state <= S_TW;
            wcnt  <= waits - 2'd1;
          end else state <= S_T3;
        S_TW:
          if (wcnt == 2'd0) state <= S_T3;
          else wcnt <= wcnt - 2'd1;
        S_T3:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_ti_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_TI |=> state == S_T1);
  p_ti_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_TI |-> (&bus_cs_n && bus_rd_n && bus_wr_n && !bus_data_oe));
  p_rr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_internal && !req_write && last_st && hist_v && hist_rd &&
    req_area != hist_area && rr_en && adv_mode |=> state == S_TI);
  p_war_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_internal && req_write && last_st && hist_v && hist_rd && wr_en
    |=> state == S_TI);
  p_same_area_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_internal && !req_write && req_area == hist_area |=> state != S_TI);
  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  p_ready_ti_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_TI |-> !req_ready);

endmodule

// File: tb/ext_bus_idle_seq_tb_top.sv
module ext_bus_idle_seq_tb_top;
  localparam int AREAS = 4;
  localparam int AW = 16;
  localparam int ABW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic adv_mode = 1'b1, cfg_we = 1'b0, cfg_rr_en = 1'b1, cfg_wr_en = 1'b1;
  logic req_valid = 1'b0, req_internal = 1'b0, req_write = 1'b0;
  logic [ABW-1:0] req_area = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, bus_rd_n, bus_wr_n, bus_data_oe;
  logic [AW-1:0] bus_addr;
  logic [AREAS-1:0] bus_cs_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ext_bus_idle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .adv_mode(adv_mode), .cfg_we(cfg_we),
    .cfg_rr_en(cfg_rr_en), .cfg_wr_en(cfg_wr_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_internal(req_internal), .req_write(req_write),
    .req_area(req_area), .req_addr(req_addr), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_data_oe(bus_data_oe));

  function automatic int cyc_len(int a);
    case (a)
      0: return 3;
      1: return 2;
      2: return 5;
      default: return 4;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issue(int a, bit w, bit intl);
    req_area = ABW'(a);
    req_write = w;
    req_internal = intl;
    req_addr = AW'(16'h1000 + a);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    req_internal = 1'b0;
  endtask

  task automatic measure(int a, bit w, int eg, string gtag);
    int g = 0;
    int len = cyc_len(a);
    @(negedge clk);
    while (&bus_cs_n && g < 4) begin
      chk(bus_rd_n && bus_wr_n && !bus_data_oe, "R1", int'(bus_data_oe), 0);
      chk(!req_ready, "R10", int'(req_ready), 0);
      g++;
      @(negedge clk);
    end
    chk(g == eg, gtag, g, eg);
    for (int k = 0; k < len; k++) begin
      chk(bus_cs_n == ~(AREAS'(1) << a), "R7", int'(bus_cs_n), int'(~(4'(1) << a)));
      chk(bus_rd_n == w, "R8", int'(bus_rd_n), int'(w));
      chk(bus_wr_n == !(w && k > 0), "R8", int'(bus_wr_n), int'(!(w && k > 0)));
      chk(bus_data_oe == w, "R8", int'(bus_data_oe), int'(w));
      chk(req_ready == (k == len - 1), "R10", int'(req_ready), int'(k == len - 1));
      if (k < len - 1) @(negedge clk);
    end
  endtask

  task automatic set_cfg(bit rr, bit wr);
    @(negedge clk);
    cfg_rr_en = rr;
    cfg_wr_en = wr;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(&bus_cs_n && bus_rd_n && bus_wr_n && !bus_data_oe, "R10", int'(bus_cs_n), 15);
    chk(req_ready, "R10", int'(req_ready), 1);

    // R5: defaults after reset give both insertions without any cfg write
    issue(0, 0, 0); measure(0, 0, 0, "R9");
    issue(2, 0, 0); measure(2, 0, 1, "R5");
    issue(1, 1, 0); measure(1, 1, 1, "R5");
    @(negedge clk); @(negedge clk);

    // R9: internal access between reads clears history
    @(negedge clk);
    issue(0, 0, 0); measure(0, 0, 0, "R9");
    issue(0, 0, 1);
    @(negedge clk);
    chk(&bus_cs_n && !bus_data_oe, "R9", int'(bus_cs_n), 15);
    issue(1, 0, 0); measure(1, 0, 0, "R9");
    // R9: one idle bus clock clears history
    @(negedge clk);
    issue(3, 0, 0); measure(3, 0, 0, "R9");
    @(negedge clk);
    issue(1, 1, 0); measure(1, 1, 0, "R9");
    @(negedge clk); @(negedge clk);

    for (int m = 0; m < 8; m++) begin
      bit rr = m[0], wr = m[1], adv = m[2];
      set_cfg(rr, wr);
      adv_mode = adv;
      for (int a1 = 0; a1 < AREAS; a1++)
        for (int w1 = 0; w1 < 2; w1++)
          for (int a2 = 0; a2 < AREAS; a2++)
            for (int w2 = 0; w2 < 2; w2++) begin
              bit idle = (w1 == 0) && ((w2 == 1) ? wr : (a1 != a2 && rr && adv));
              string tg;
              if (idle) tg = (w2 == 1) ? "R3" : "R2";
              else if (w1 == 0 && w2 == 0 && a1 != a2 && rr && !adv) tg = "R6";
              else tg = "R4";
              @(negedge clk);
              issue(a1, w1[0], 0); measure(a1, w1[0], 0, "R9");
              issue(a2, w2[0], 0); measure(a2, w2[0], idle ? 1 : 0, tg);
              @(negedge clk);
              chk(&bus_cs_n, "R7", int'(bus_cs_n), 15);
            end
    end
    finish_run();
  end
endmodule